// File: doc/BRIEF.md
# Transceiver Power-Mode and Wake Controller

This block sequences the power modes of a single-wire, low-speed bus transceiver. There are three modes: sleep, standby and active. In each mode the block sets the transmitter enable, the receive-line pull-down, the regulator-inhibit drive and the bus termination switch.

A host enable line moves the block between sleep and active mode. While the transceiver sleeps, two digital glitch filters watch for wake activity. One watches for dominant bus activity and the other for a low pulse on a local wake input. A wake that passes its filter puts the block in standby. Standby powers the regulator and pulls the receive line low so that the host knows a wake happened. The host then raises enable to reach active mode.

A supply-undervoltage flag overrides all of this and keeps the block asleep. A fault input shuts the transmitter off in the same cycle it rises.

Top module: `xcvr_power_ctrl`

## Requirements
- R1: After reset the block is in sleep mode: `tx_en`=0, `rxd_low`=0 (receive line released), `inh_en`=0 (inhibit output high impedance), `term_en`=0.
- R2: In standby the outputs are `tx_en`=0, `rxd_low`=1, `inh_en`=1 and `term_en`=1. In active mode `inh_en`=1, `term_en`=1 and `rxd_low` is the inverse of `bus_rec` (`bus_rec`=1 means recessive, `bus_rec`=0 means dominant).
- R3: In sleep mode, a high level on `en_in`, once it has passed its two-flop synchronizer, moves the block to active mode with no standby step.
- R4: In active mode, a low level on `en_in`, once synchronized, moves the block to sleep mode.
- R5: A bus wake moves the block from sleep to standby. It needs a change from recessive to dominant, seen while asleep, after which the bus stays dominant for FILT_TICKS pulses of `tick_us`. A return to recessive before that point restarts the filter. A bus that is already dominant when sleep is entered does not wake the block until it has first gone recessive.
- R6: A local wake moves the block from sleep to standby. It needs a falling edge on the synchronized `wake_n_in`, after which the input stays low for FILT_TICKS pulses of `tick_us`. Shorter low pulses have no effect.
- R7: In standby, `en_in` going high moves the block to active mode.
- R8: While `uv_flag` is high the block is held in sleep mode, even with `en_in` high. A wake that qualifies while `uv_flag` is high is discarded, and the block stays asleep after `uv_flag` falls.
- R9: `tx_en` is 0 in the same cycle that `fault` is 1. It is restored as soon as `fault` returns to 0 while the block is in active mode.
- R10: Wake activity outside sleep mode is not retained. A local wake held through active mode does not wake the block after it returns to sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_us | input | 1 | One-cycle strobe, once per microsecond |
| en_in | input | 1 | Host enable, asynchronous |
| wake_n_in | input | 1 | Local wake input, active low, asynchronous |
| bus_rec | input | 1 | Receiver bus level: 1 recessive, 0 dominant |
| uv_flag | input | 1 | Supply undervoltage indication |
| fault | input | 1 | Thermal or other driver fault |
| tx_en | output | 1 | Transmitter enable |
| rxd_low | output | 1 | Pull receive line low; 0 releases it |
| inh_en | output | 1 | Drive inhibit output high; 0 leaves it high impedance |
| term_en | output | 1 | Bus termination switch on |

## Verification
Two pairs of functions can land in the same cycle.

- **Wake expiry against host enable.** A filter can expire in the same cycle that a synchronized enable arrives. The bench holds a local wake low and raises enable at a sweep of clock offsets around the filter expiry. Every offset must end in active mode, with no standby left behind.
- **Wake expiry against undervoltage.** The bench holds `uv_flag` high across a full bus wake. The block must stay asleep both during the wake and after the flag falls.

Random glitch lengths just below the filter time check that short pulses are rejected.

// File: rtl/xcvr_power_ctrl.sv
module xcvr_power_ctrl #(
  parameter int FILT_TICKS = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_us,
  input  logic en_in,
  input  logic wake_n_in,
  input  logic bus_rec,
  input  logic uv_flag,
  input  logic fault,
  output logic tx_en,
  output logic rxd_low,
  output logic inh_en,
  output logic term_en
);

  localparam int CW = $clog2(FILT_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(FILT_TICKS - 1);

  typedef enum logic [1:0] {M_SLEEP, M_STBY, M_ACT} mode_t;

  mode_t mode, mode_nxt;
  logic [1:0] en_sr, wk_sr;
  logic en_s, wk_s, wk_prev, bus_prev;
  logic bw_arm, lw_arm, bw_hit, lw_hit, asleep;
  logic [CW-1:0] bw_cnt, lw_cnt;

  assign en_s   = en_sr[1];
  assign wk_s   = wk_sr[1];
  assign asleep = (mode == M_SLEEP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_sr    <= 2'b00;
      wk_sr    <= 2'b11;
      wk_prev  <= 1'b1;
      bus_prev <= 1'b1;
    end else begin
      en_sr    <= {en_sr[0], en_in};
      wk_sr    <= {wk_sr[0], wake_n_in};
      wk_prev  <= wk_s;
      bus_prev <= bus_rec;
    end
  end

  assign bw_hit = asleep & bw_arm & tick_us & ~bus_rec & (bw_cnt == LAST);
  assign lw_hit = asleep & lw_arm & tick_us & ~wk_s & (lw_cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bw_arm <= 1'b0;
      bw_cnt <= '0;
    end else if (!asleep || bus_rec) begin
      bw_arm <= 1'b0;
      bw_cnt <= '0;
    end else if (bus_prev) begin
      bw_arm <= 1'b1;
      bw_cnt <= '0;
    end else if (bw_arm && tick_us) begin
      if (bw_cnt == LAST) begin
        bw_arm <= 1'b0;
        bw_cnt <= '0;
      end else begin
        bw_cnt <= bw_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lw_arm <= 1'b0;
      lw_cnt <= '0;
    end else if (!asleep || wk_s) begin
      lw_arm <= 1'b0;
      lw_cnt <= '0;
    end else if (wk_prev) begin
      lw_arm <= 1'b1;
      lw_cnt <= '0;
    end else if (lw_arm && tick_us) begin
      if (lw_cnt == LAST) begin
        lw_arm <= 1'b0;
        lw_cnt <= '0;
      end else begin
        lw_cnt <= lw_cnt + 1'b1;
      end
    end
  end

  always_comb begin
    mode_nxt = mode;
    if (uv_flag) begin
      mode_nxt = M_SLEEP;
    end else begin
      case (mode)
        M_SLEEP: if (en_s) mode_nxt = M_ACT;
                 else if (bw_hit || lw_hit) mode_nxt = M_STBY;
        M_STBY:  if (en_s) mode_nxt = M_ACT;
        M_ACT:   if (!en_s) mode_nxt = M_SLEEP;
        default: mode_nxt = M_SLEEP;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode <= M_SLEEP;
    else        mode <= mode_nxt;
  end

  assign tx_en   = (mode == M_ACT) & ~fault;
  assign rxd_low = (mode == M_STBY) | ((mode == M_ACT) & ~bus_rec);
  assign inh_en  = ~asleep;
  assign term_en = ~asleep;

  // R8
  uv_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uv_flag |=> (mode == M_SLEEP));

  // R5
  stby_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == M_STBY) && ($past(mode) != M_STBY)) |-> $past(bw_hit || lw_hit));

  // R7
  stby_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == M_STBY) && !en_s && !uv_flag) |=> (mode == M_STBY));

  // R4
  act_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == M_ACT) && !en_s) |=> (mode == M_SLEEP));

  // R10
  wake_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bw_arm || lw_arm) |-> $past(mode == M_SLEEP));

  // R9
  fault_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> !tx_en);

endmodule

// File: tb/xcvr_power_ctrl_bench.sv
module xcvr_power_ctrl_bench;
  localparam int FILT = 50;
  localparam int TDIV = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_us = 1'b0;
  logic en_in = 1'b0, wake_n_in = 1'b1, bus_rec = 1'b1, uv_flag = 1'b0, fault = 1'b0;
  logic tx_en, rxd_low, inh_en, term_en;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  xcvr_power_ctrl #(.FILT_TICKS(FILT)) u_xcvr_power_ctrl (
    .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .en_in(en_in),
    .wake_n_in(wake_n_in), .bus_rec(bus_rec), .uv_flag(uv_flag), .fault(fault),
    .tx_en(tx_en), .rxd_low(rxd_low), .inh_en(inh_en), .term_en(term_en));

  int tdiv = 0;
  always @(negedge clk) begin
    tdiv    <= (tdiv == TDIV - 1) ? 0 : tdiv + 1;
    tick_us <= (tdiv == TDIV - 1);
  end

  // mode codes: 0 sleep, 1 standby, 2 active; vector {tx_en,rxd_low,inh_en,term_en}
  function automatic logic [3:0] exp_out(input int m, input logic bus, input logic flt);
    case (m)
      1:       return 4'b0111;
      2:       return {~flt, ~bus, 2'b11};
      default: return 4'b0000;
    endcase
  endfunction

  task automatic chk(input string tag, input int m);
    logic [3:0] got, exp;
    #1;
    got = {tx_en, rxd_low, inh_en, term_en};
    exp = exp_out(m, bus_rec, fault);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic settle(input int n = 8);
    repeat (n) @(negedge clk);
  endtask

  task automatic hold_ticks(input int t);
    repeat (t * TDIV) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h1F2E3D4C));
    settle(3);
    rst_n = 1'b1;
    settle(2);
    chk("R1 reset sleep", 0);

    en_in = 1'b1; settle();
    chk("R3 sleep to active", 2);
    for (int i = 0; i < 12; i++) begin
      bus_rec = 1'($urandom_range(0, 1));
      fault   = 1'($urandom_range(0, 1));
      chk(fault ? "R9 fault gates tx" : "R2 active follows bus", 2);
    end
    fault = 1'b0;
    chk("R9 tx restored", 2);
    bus_rec = 1'b1;
    en_in = 1'b0; settle();
    chk("R4 active to sleep", 0);

    for (int i = 0; i < 5; i++) begin
      wake_n_in = 1'b0; hold_ticks($urandom_range(2, FILT - 12));
      wake_n_in = 1'b1; settle(12);
      chk("R6 short local pulse ignored", 0);
    end
    wake_n_in = 1'b0; hold_ticks(FILT + 20);
    chk("R6 local wake to standby", 1);
    chk("R2 standby outputs", 1);
    wake_n_in = 1'b1;
    en_in = 1'b1; settle();
    chk("R7 standby to active", 2);
    en_in = 1'b0; settle();
    chk("R4 back to sleep", 0);

    for (int i = 0; i < 5; i++) begin
      bus_rec = 1'b0; hold_ticks($urandom_range(2, FILT - 12));
      bus_rec = 1'b1; settle(12);
      chk("R5 short bus pulse ignored", 0);
    end
    bus_rec = 1'b0; hold_ticks(FILT + 20);
    chk("R5 bus wake to standby", 1);
    bus_rec = 1'b1;
    en_in = 1'b1; settle();
    chk("R7 standby to active after bus wake", 2);
    bus_rec = 1'b0;
    en_in = 1'b0; settle();
    hold_ticks(FILT + 20);
    chk("R5 dominant at entry no wake", 0);
    bus_rec = 1'b1; settle(4);
    bus_rec = 1'b0; hold_ticks(FILT + 20);
    chk("R5 wake after recessive gap", 1);
    bus_rec = 1'b1;
    en_in = 1'b1; settle();

    wake_n_in = 1'b0; hold_ticks(FILT + 20);
    wake_n_in = 1'b1; settle();
    en_in = 1'b0; settle(); hold_ticks(FILT + 10);
    chk("R10 wake in active not kept", 0);

    uv_flag = 1'b1; en_in = 1'b1; settle();
    chk("R8 uv blocks enable", 0);
    uv_flag = 1'b0; settle();
    chk("R8 enable after uv clears", 2);
    uv_flag = 1'b1; settle();
    chk("R8 uv forces sleep from active", 0);
    en_in = 1'b0;
    bus_rec = 1'b0; hold_ticks(FILT + 20);
    chk("R8 wake under uv held asleep", 0);
    uv_flag = 1'b0; settle(); hold_ticks(10);
    chk("R8 wake under uv discarded", 0);
    bus_rec = 1'b1; settle();

    for (int off = FILT * TDIV - 12; off <= FILT * TDIV + 12; off += 3) begin
      wake_n_in = 1'b0;
      settle(off);
      en_in = 1'b1; settle();
      chk("R7 enable near wake expiry", 2);
      wake_n_in = 1'b1;
      en_in = 1'b0; settle();
      chk("R4 sleep after sweep", 0);
    end

    finish_run();
  end
endmodule